// File: doc/BRIEF.md
# Register-Write Command Stream Decoder

This block accepts a stream of 32-bit command words over a valid/ready input and interprets each word that arrives while no payload is outstanding as a command. The opcode sits in the top nibble. Write commands become a series of single-cycle register-write transactions. Each transaction carries the current class, a 12-bit register offset and 32 bits of data.

Two control commands are not writes and are reported on their own strobes. A jump command yields a 16-byte-aligned restart address. A fetch-indirection command yields a count and an addressing mode, plus an inline register offset when one is marked present. Fetching that memory, the client modules and any synchronisation logic are outside this block.

The decoder keeps a current-class register and the number of payload words the active command still expects. Any opcode value it does not recognise sets a sticky error flag, and the word is discarded.

Top module: `regcmd_decoder`

## Requirements
- R1: After reset every output strobe is 0, `errFlag` is 0, the current class is 0, and `inReady` is 1 from the first cycle after reset is released.
- R2: Opcode 0 (word bits 31:28) sets the current class to bits 15:6 and the base offset to bits 27:16. It then takes one payload word per set bit of mask bits 5:0, exactly as R5 describes. Every later write carries the class.
- R3: Opcode 1 takes N payload words, where N is bits 15:0. Payload word i is written to offset (bits 27:16) + i. N = 0 produces no writes.
- R4: Opcode 2 takes N payload words (bits 15:0), all written to the offset in bits 27:16. The word 0x20000000 produces no write, and the next word is decoded as a command.
- R5: Opcode 3 takes one payload word per set bit of mask bits 15:0, starting from the lowest set bit. Each word is written to offset + that bit's index.
- R6: Opcode 4 produces one write to offset bits 27:16. Its data is bits 15:0, zero-extended. It takes no payload.
- R7: While payload words are outstanding, every accepted word is written as data whatever its top nibble holds.
- R8: Opcode 5 pulses `restartValid` with `restartAddr` = word bits 27:0 shifted left by 4.
- R9: Opcode 6 pulses `gatherValid` with count = bits 13:0, offset-present = bit 15, incrementing = bit 14 and offset = bits 27:16.
- R10: An opcode of 7 to 15 sets `errFlag`, which stays set until reset. The word produces no write and no event.
- R11: Each result appears exactly one clock after the edge that accepts its word, and it lasts for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Command word present |
| inWord | input | 32 | Command or payload word |
| inReady | output | 1 | Decoder accepts a word this cycle |
| wrValid | output | 1 | Register-write strobe |
| wrClass | output | 10 | Class of the write |
| wrOffset | output | 12 | Register offset of the write |
| wrData | output | 32 | Write data |
| restartValid | output | 1 | Jump event strobe |
| restartAddr | output | 32 | Jump target byte address |
| gatherValid | output | 1 | Fetch-indirection event strobe |
| gatherCount | output | 14 | Words to fetch |
| gatherOffValid | output | 1 | Inline offset present |
| gatherOffset | output | 12 | Inline register offset |
| gatherIncr | output | 1 | Incrementing (1) or fixed (0) addressing |
| errFlag | output | 1 | Sticky unknown-opcode flag |

## Verification
Every write, jump, fetch and error result is due exactly one clock after the rising edge that accepts its word. The bench therefore drives each word on a falling edge and checks the matching result on the next falling edge, at the same moment it drives the following word. Command words themselves must leave the write strobe low at that point. One-cycle pulse width is checked by idling the input for one cycle after a result and confirming the strobe has dropped.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 12;
  localparam int CLS_W  = 10;
  localparam int CNT_W  = 16;
  localparam int MASK_W = 16;
  localparam int SMASK_W = 6;
  localparam int GCNT_W = 14;
  localparam int IDX_W  = $clog2(MASK_W);

  localparam logic [3:0] OP_CLASS = 4'd0;
  localparam logic [3:0] OP_INCR  = 4'd1;
  localparam logic [3:0] OP_FIXED = 4'd2;
  localparam logic [3:0] OP_MASK  = 4'd3;
  localparam logic [3:0] OP_IMM   = 4'd4;
  localparam logic [3:0] OP_JUMP  = 4'd5;
  localparam logic [3:0] OP_GATH  = 4'd6;

  typedef enum logic [1:0] {MD_IDLE, MD_INCR, MD_FIXED, MD_MASK} mode_e;

  typedef struct packed {
    logic             loadClass;
    logic             loadBase;
    logic             emitImm;
    logic             emitPay;
    logic [OFF_W-1:0] idx;
    logic             jumpEv;
    logic             gathEv;
    logic             errSet;
  } strobe_t;

  function automatic logic [IDX_W-1:0] lowIdx(input logic [MASK_W-1:0] m);
    lowIdx = '0;
    for (int b = MASK_W - 1; b >= 0; b--) begin
      if (m[b]) lowIdx = IDX_W'(b);
    end
  endfunction
endpackage

// File: rtl/rcd_ctrl.sv
module rcd_ctrl
  import rcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output strobe_t           st
);
  mode_e             mode;
  logic [CNT_W-1:0]  remain;
  logic [MASK_W-1:0] maskBits;
  logic [OFF_W-1:0]  stepIdx;
  logic              readyQ;
  logic              acc;
  logic [3:0]        op;
  logic [MASK_W-1:0] maskNext;

  assign inReady  = readyQ;
  assign acc      = inValid && readyQ;
  assign op       = inWord[WORD_W-1 -: 4];
  assign maskNext = maskBits & (maskBits - 1'b1);

  always_comb begin
    st = '0;
    if (acc) begin
      if (mode != MD_IDLE) begin
        st.emitPay = 1'b1;
        case (mode)
          MD_INCR: st.idx = stepIdx;
          MD_MASK: st.idx = OFF_W'(lowIdx(maskBits));
          default: st.idx = '0;
        endcase
      end else begin
        case (op)
          OP_CLASS: begin st.loadClass = 1'b1; st.loadBase = 1'b1; end
          OP_INCR, OP_FIXED, OP_MASK: st.loadBase = 1'b1;
          OP_IMM:  st.emitImm = 1'b1;
          OP_JUMP: st.jumpEv  = 1'b1;
          OP_GATH: st.gathEv  = 1'b1;
          default: st.errSet  = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MD_IDLE;
      remain   <= '0;
      maskBits <= '0;
      stepIdx  <= '0;
      readyQ   <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      if (acc) begin
        if (mode != MD_IDLE) begin
          case (mode)
            MD_INCR, MD_FIXED: begin
              remain  <= remain - 1'b1;
              stepIdx <= stepIdx + 1'b1;
              if (remain == CNT_W'(1)) mode <= MD_IDLE;
            end
            default: begin
              maskBits <= maskNext;
              if (maskNext == '0) mode <= MD_IDLE;
            end
          endcase
        end else begin
          case (op)
            OP_CLASS: begin
              maskBits <= MASK_W'(inWord[SMASK_W-1:0]);
              if (inWord[SMASK_W-1:0] != '0) mode <= MD_MASK;
            end
            OP_INCR, OP_FIXED: begin
              remain  <= inWord[CNT_W-1:0];
              stepIdx <= '0;
              if (inWord[CNT_W-1:0] != '0) mode <= (op == OP_INCR) ? MD_INCR : MD_FIXED;
            end
            OP_MASK: begin
              maskBits <= inWord[MASK_W-1:0];
              if (inWord[MASK_W-1:0] != '0) mode <= MD_MASK;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R11: at most one kind of result per accepted word
  a_r11_single_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.emitPay, st.emitImm, st.jumpEv, st.gathEv, st.errSet}));

  // R7: a word taken as payload never raises an event or error
  a_r7_payload_is_data: assert property (@(posedge clk) disable iff (!rstN)
    (acc && mode != MD_IDLE) |-> !(st.errSet || st.jumpEv || st.gathEv || st.emitImm));

  // R3: every payload word of a counted write uses up one count
  a_r3_count_drops: assert property (@(posedge clk) disable iff (!rstN)
    (acc && (mode == MD_INCR || mode == MD_FIXED)) |=> remain == $past(remain) - 1'b1);

  // R5: every masked payload word retires exactly one mask bit
  a_r5_mask_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (acc && mode == MD_MASK) |=> $countones(maskBits) == $countones($past(maskBits)) - 1);
endmodule

// File: rtl/rcd_path.sv
module rcd_path
  import rcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [WORD_W-1:0] inWord,
  output logic              wrValid,
  output logic [CLS_W-1:0]  wrClass,
  output logic [OFF_W-1:0]  wrOffset,
  output logic [WORD_W-1:0] wrData,
  output logic              restartValid,
  output logic [WORD_W-1:0] restartAddr,
  output logic              gatherValid,
  output logic [GCNT_W-1:0] gatherCount,
  output logic              gatherOffValid,
  output logic [OFF_W-1:0]  gatherOffset,
  output logic              gatherIncr,
  output logic              errFlag
);
  localparam int OFF_LO = 16;
  localparam int CLS_LO = 6;
  localparam int IMM_W  = 16;

  logic [CLS_W-1:0] curClass;
  logic [OFF_W-1:0] baseOff;
  logic [OFF_W-1:0] wordOff;

  assign wordOff = inWord[OFF_LO +: OFF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curClass       <= '0;
      baseOff        <= '0;
      wrValid        <= 1'b0;
      wrClass        <= '0;
      wrOffset       <= '0;
      wrData         <= '0;
      restartValid   <= 1'b0;
      restartAddr    <= '0;
      gatherValid    <= 1'b0;
      gatherCount    <= '0;
      gatherOffValid <= 1'b0;
      gatherOffset   <= '0;
      gatherIncr     <= 1'b0;
      errFlag        <= 1'b0;
    end else begin
      wrValid      <= st.emitPay || st.emitImm;
      restartValid <= st.jumpEv;
      gatherValid  <= st.gathEv;
      errFlag      <= errFlag || st.errSet;
      if (st.loadClass) curClass <= inWord[CLS_LO +: CLS_W];
      if (st.loadBase)  baseOff  <= wordOff;
      if (st.emitPay) begin
        wrClass  <= curClass;
        wrOffset <= baseOff + st.idx;
        wrData   <= inWord;
      end else if (st.emitImm) begin
        wrClass  <= curClass;
        wrOffset <= wordOff;
        wrData   <= WORD_W'(inWord[IMM_W-1:0]);
      end
      if (st.jumpEv) restartAddr <= {inWord[WORD_W-5:0], 4'b0000};
      if (st.gathEv) begin
        gatherCount    <= inWord[GCNT_W-1:0];
        gatherOffValid <= inWord[15];
        gatherIncr     <= inWord[14];
        gatherOffset   <= wordOff;
      end
    end
  end

  // R10: the error flag never clears outside reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R10: a rejected word leaves no write or event behind
  a_r10_err_silent: assert property (@(posedge clk) disable iff (!rstN)
    st.errSet |=> !(wrValid || restartValid || gatherValid));

  // R2: the class seen on a payload write is the one loaded earlier
  a_r2_class_follows: assert property (@(posedge clk) disable iff (!rstN)
    st.emitPay |=> wrClass == $past(curClass));
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import rcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              wrValid,
  output logic [CLS_W-1:0]  wrClass,
  output logic [OFF_W-1:0]  wrOffset,
  output logic [WORD_W-1:0] wrData,
  output logic              restartValid,
  output logic [WORD_W-1:0] restartAddr,
  output logic              gatherValid,
  output logic [GCNT_W-1:0] gatherCount,
  output logic              gatherOffValid,
  output logic [OFF_W-1:0]  gatherOffset,
  output logic              gatherIncr,
  output logic              errFlag
);
  strobe_t st;

  rcd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .st(st)
  );

  rcd_path uPath (
    .clk(clk), .rstN(rstN), .st(st), .inWord(inWord),
    .wrValid(wrValid), .wrClass(wrClass), .wrOffset(wrOffset), .wrData(wrData),
    .restartValid(restartValid), .restartAddr(restartAddr),
    .gatherValid(gatherValid), .gatherCount(gatherCount),
    .gatherOffValid(gatherOffValid), .gatherOffset(gatherOffset),
    .gatherIncr(gatherIncr), .errFlag(errFlag)
  );
endmodule

// File: tb/sim_regcmd_decoder.sv
module sim_regcmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic [31:0] word;
    logic        wr;
    logic [11:0] off;
    logic [31:0] data;
    logic [9:0]  cls;
  } vec_t;

  // setclass, masked payload, incr, fixed, no-op, mask, immediate, payload that looks like opcode 7
  localparam vec_t VEC [NVEC] = '{
    '{32'h0010_0A85, 1'b0, 12'h000, 32'h0000_0000, 10'h000},
    '{32'h1111_1111, 1'b1, 12'h010, 32'h1111_1111, 10'h02A},
    '{32'h2222_2222, 1'b1, 12'h012, 32'h2222_2222, 10'h02A},
    '{32'h1100_0003, 1'b0, 12'h000, 32'h0000_0000, 10'h000},
    '{32'h0000_00A0, 1'b1, 12'h100, 32'h0000_00A0, 10'h02A},
    '{32'h0000_00A1, 1'b1, 12'h101, 32'h0000_00A1, 10'h02A},
    '{32'h0000_00A2, 1'b1, 12'h102, 32'h0000_00A2, 10'h02A},
    '{32'h2020_0002, 1'b0, 12'h000, 32'h0000_0000, 10'h000},
    '{32'h0000_00B0, 1'b1, 12'h020, 32'h0000_00B0, 10'h02A},
    '{32'h0000_00B1, 1'b1, 12'h020, 32'h0000_00B1, 10'h02A},
    '{32'h2000_0000, 1'b0, 12'h000, 32'h0000_0000, 10'h000},
    '{32'h3040_8001, 1'b0, 12'h000, 32'h0000_0000, 10'h000},
    '{32'h0000_00C0, 1'b1, 12'h040, 32'h0000_00C0, 10'h02A},
    '{32'h0000_00C1, 1'b1, 12'h04F, 32'h0000_00C1, 10'h02A},
    '{32'h4055_BEEF, 1'b1, 12'h055, 32'h0000_BEEF, 10'h02A},
    '{32'h1200_0001, 1'b0, 12'h000, 32'h0000_0000, 10'h000},
    '{32'h7000_0000, 1'b1, 12'h200, 32'h7000_0000, 10'h02A}
  };
  localparam string TAG [NVEC] = '{"R2","R2","R2","R3","R3","R3","R3","R4","R4","R4",
                                   "R4","R5","R5","R5","R6","R7","R7"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic inReady, wrValid, restartValid, gatherValid, gatherOffValid, gatherIncr, errFlag;
  logic [9:0] wrClass;
  logic [11:0] wrOffset, gatherOffset;
  logic [31:0] wrData, restartAddr;
  logic [13:0] gatherCount;
  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regcmd_decoder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord), .inReady(inReady),
    .wrValid(wrValid), .wrClass(wrClass), .wrOffset(wrOffset), .wrData(wrData),
    .restartValid(restartValid), .restartAddr(restartAddr),
    .gatherValid(gatherValid), .gatherCount(gatherCount),
    .gatherOffValid(gatherOffValid), .gatherOffset(gatherOffset),
    .gatherIncr(gatherIncr), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a word, then move to the falling edge where its result is visible
  task automatic send(input logic [31:0] w);
    inValid = 1'b1;
    inWord  = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle();
    inValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 inReady", 32'(inReady), 32'd1);
    check("R1 wrValid", 32'(wrValid), 32'd0);
    check("R1 errFlag", 32'(errFlag), 32'd0);
    check("R1 events", 32'({restartValid, gatherValid}), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      inValid = 1'b1;
      inWord  = VEC[i].word;
      @(negedge clk);
      check({TAG[i], " wrValid"}, 32'(wrValid), 32'(VEC[i].wr));
      if (VEC[i].wr) begin
        check({TAG[i], " offset"}, 32'(wrOffset), 32'(VEC[i].off));
        check({TAG[i], " data"}, wrData, VEC[i].data);
        check({TAG[i], " class"}, 32'(wrClass), 32'(VEC[i].cls));
      end
    end
    inValid = 1'b0;
    check("R7 no error from payload", 32'(errFlag), 32'd0);
    idle();
    check("R11 one-cycle pulse", 32'(wrValid), 32'd0);

    // R3: zero-count incrementing write, next word is a command
    send(32'h1300_0000);
    check("R3 zero count no write", 32'(wrValid), 32'd0);
    send(32'h4301_0007);
    check("R3 next word decoded", 32'(wrOffset), 32'h301);
    check("R3 next word data", wrData, 32'h0000_0007);

    // R8: restart target
    send(32'h5000_1234);
    check("R8 restartValid", 32'(restartValid), 32'd1);
    check("R8 restartAddr", restartAddr, 32'h0001_2340);
    check("R8 no write", 32'(wrValid), 32'd0);
    idle();
    check("R11 restart pulse drops", 32'(restartValid), 32'd0);

    // R9: three gather variants
    send(32'h6000_0040);
    check("R9 gatherValid", 32'(gatherValid), 32'd1);
    check("R9 plain fields", {gatherCount, gatherOffValid, gatherIncr}, {14'h040, 1'b0, 1'b0});
    send(32'h6033_C005);
    check("R9 incr fields", {gatherCount, gatherOffValid, gatherIncr}, {14'h005, 1'b1, 1'b1});
    check("R9 offset", 32'(gatherOffset), 32'h033);
    send(32'h6044_8007);
    check("R9 fixed fields", {gatherCount, gatherOffValid, gatherIncr}, {14'h007, 1'b1, 1'b0});
    check("R9 offset fixed", 32'(gatherOffset), 32'h044);

    // R10: unknown opcodes
    send(32'h7000_0003);
    check("R10 errFlag", 32'(errFlag), 32'd1);
    check("R10 dropped", 32'({wrValid, restartValid, gatherValid}), 32'd0);
    send(32'hF123_4567);
    check("R10 still dropped", 32'({wrValid, restartValid, gatherValid}), 32'd0);
    send(32'h4011_0022);
    check("R10 sticky", 32'(errFlag), 32'd1);
    check("R10 later command works", 32'(wrOffset), 32'h011);

    // R1: reset clears error and class
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 err cleared", 32'(errFlag), 32'd0);
    send(32'h4012_0001);
    check("R1 class zero", 32'(wrClass), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule